// File: doc/BRIEF.md
# Fetch and Branch Sequencer for a Three-Stage Shared-Port Core

This block steers instruction fetch and the flow of work through a three-stage in-order core (fetch, decode, execute) whose code and data share one synchronous memory port. It owns the program counter and drives the port address. Each cycle it tells the downstream stages whether they hold a real instruction or a bubble, and whether the port is serving code or data. Memory read data appears one cycle after the address.

Branches are resolved in execute and fetch always runs straight on, so branches are predicted not-taken. A taken branch has two delay slots. The instruction in decode when the branch resolves (the first slot) still executes. The word being fetched in that cycle (the second slot) is squashed into a bubble. A load or store seen in decode takes the port for one cycle once it reaches execute. During that cycle the PC and the decode contents are held, and fetch resumes at the held PC afterwards. An external hold input freezes everything.

The controller has three states. RUN is normal flow. DATA is the cycle in which the port carries the load/store address. RESUME is the cycle that fetches again while the load/store finishes. The transitions are:
- RUN to DATA when decode holds a valid load/store, and RUN to RUN otherwise.
- DATA to RESUME always.
- RESUME to DATA when the instruction now in decode is itself a load/store, and RESUME to RUN otherwise.
- Every state stays where it is while hold is asserted.

Top module: `fetch_seq`

## Requirements
- R1: After reset the fetch address is RESET_PC (0x00000000 by default), mem_sel_data_o is 0 (code), and dec_valid_o and ex_valid_o are both 0.
- R2: In RUN with no branch and no load/store, each clock advances the fetch address by STEP (4). dec_valid_o becomes 1 one cycle after a fetch, and ex_valid_o copies the previous dec_valid_o.
- R3: A branch in execute that is not taken (ex_valid_o=1, br_taken_i=0) costs nothing: the next fetch address is the sequential one.
- R4: A taken branch in RUN (ex_valid_o=1, br_taken_i=1) makes the next fetch address br_target_i. In that next cycle dec_valid_o=0 (second slot squashed) and ex_valid_o=1 (first slot executes).
- R5: The branch target reaches execute (ex_valid_o=1) three cycles after the taken branch was in execute, with one bubble cycle in execute between.
- R6: When decode holds a valid load/store (dec_valid_o=1, ls_req_i=1) in an advancing cycle, the next cycle is DATA. In DATA, mem_sel_data_o=1, mem_addr_o=ls_addr_i and ex_valid_o=1.
- R7: DATA lasts exactly one unheld cycle and is followed by RESUME. RESUME fetches at the held PC (the PC is not advanced in DATA). br_taken_i has no effect in DATA or RESUME.
- R8: If the instruction in decode during RESUME is a load/store, the controller enters DATA again on the next cycle with no RUN cycle in between.
- R9: A taken branch whose first delay slot is a load/store both redirects the PC and enters DATA. After the data cycle, fetch resumes at br_target_i, decode stays a bubble, and execute is empty one cycle later.
- R10: While hold_i=1, the PC, the state and both valid flags are frozen, and br_taken_i and ls_req_i have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | External stall, freezes all sequencer state |
| ls_req_i | input | 1 | Decode holds a load or store |
| ls_addr_i | input | AW | Data address of the load/store, used in DATA |
| br_taken_i | input | 1 | Branch in execute is taken |
| br_target_i | input | AW | Target of the branch in execute |
| mem_addr_o | output | AW | Shared memory port address |
| mem_sel_data_o | output | 1 | 1 = port serves data, 0 = port fetches code |
| dec_valid_o | output | 1 | Decode holds a valid instruction |
| ex_valid_o | output | 1 | Execute holds a valid instruction |

## Verification
The bench builds the block with AW=32, STEP=4 and RESET_PC=0. Code addresses therefore start at zero and grow in word steps, while branch targets (0x100, 0x200) and data addresses (0x8000 and up) stay far apart, so a wrong port selection shows up at once on mem_addr_o. The vector walk covers several cases:
- branches taken and not taken,
- single and back-to-back load/stores,
- a load/store in the first delay slot of a taken branch,
- hold during RUN and during DATA.

A directed reset during DATA then confirms that the reset state is restored from any state.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DATA   = 2'd1,
        ST_RESUME = 2'd2
    } seq_state_e;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_i,
    input  logic       dec_valid_i,
    input  logic       ex_valid_i,
    input  logic       ls_req_i,
    input  logic       br_taken_i,
    output seq_state_e state_o,
    output logic       advance_o,
    output logic       redirect_o,
    output logic       port_data_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       ls_in_dec;

    assign ls_in_dec = dec_valid_i && ls_req_i;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else if (!hold_i) begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    state_d = ls_in_dec ? ST_DATA : ST_RUN;
            ST_DATA:   state_d = ST_RESUME;
            ST_RESUME: state_d = ls_in_dec ? ST_DATA : ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        advance_o   = 1'b0;
        redirect_o  = 1'b0;
        port_data_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                advance_o  = 1'b1;
                redirect_o = ex_valid_i && br_taken_i;
            end
            ST_DATA: begin
                port_data_o = 1'b1;
            end
            ST_RESUME: begin
                advance_o = 1'b1;
            end
            default: begin
                advance_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R7
    data_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !hold_i) |=> (state_q == ST_RESUME));

    // R10
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> $stable(state_q));

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
    parameter int             AW       = 32,
    parameter int             STEP     = 4,
    parameter logic [AW-1:0]  RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_i,
    input  logic          advance_i,
    input  logic          redirect_i,
    input  logic [AW-1:0] target_i,
    output logic [AW-1:0] pc_o
);

    localparam logic [AW-1:0] INC = AW'(STEP);

    logic [AW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else if (!hold_i && advance_i) begin
            pc_q <= redirect_i ? target_i : pc_q + INC;
        end
    end

    assign pc_o = pc_q;

    // R10
    hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> $stable(pc_q));

    // R7
    no_advance_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance_i) |=> $stable(pc_q));

endmodule

// File: rtl/fseq_valid.sv
module fseq_valid (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic advance_i,
    input  logic redirect_i,
    output logic dec_valid_o,
    output logic ex_valid_o
);

    logic dv_q;
    logic xv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dv_q <= 1'b0;
            xv_q <= 1'b0;
        end else if (!hold_i && advance_i) begin
            dv_q <= !redirect_i;
            xv_q <= dv_q;
        end
    end

    assign dec_valid_o = dv_q;
    assign ex_valid_o  = xv_q;

    // R10
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> ($stable(dv_q) && $stable(xv_q)));

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fseq_pkg::*;
#(
    parameter int             AW       = 32,
    parameter int             STEP     = 4,
    parameter logic [AW-1:0]  RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_i,
    input  logic          ls_req_i,
    input  logic [AW-1:0] ls_addr_i,
    input  logic          br_taken_i,
    input  logic [AW-1:0] br_target_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_sel_data_o,
    output logic          dec_valid_o,
    output logic          ex_valid_o
);

    localparam logic [AW-1:0] INC = AW'(STEP);

    seq_state_e    state;
    logic          advance;
    logic          redirect;
    logic          port_data;
    logic [AW-1:0] pc;

    fseq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .hold_i      (hold_i),
        .dec_valid_i (dec_valid_o),
        .ex_valid_i  (ex_valid_o),
        .ls_req_i    (ls_req_i),
        .br_taken_i  (br_taken_i),
        .state_o     (state),
        .advance_o   (advance),
        .redirect_o  (redirect),
        .port_data_o (port_data)
    );

    fseq_pc #(
        .AW       (AW),
        .STEP     (STEP),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk        (clk),
        .rst        (rst),
        .hold_i     (hold_i),
        .advance_i  (advance),
        .redirect_i (redirect),
        .target_i   (br_target_i),
        .pc_o       (pc)
    );

    fseq_valid u_valid (
        .clk         (clk),
        .rst         (rst),
        .hold_i      (hold_i),
        .advance_i   (advance),
        .redirect_i  (redirect),
        .dec_valid_o (dec_valid_o),
        .ex_valid_o  (ex_valid_o)
    );

    assign mem_sel_data_o = port_data;
    assign mem_addr_o     = port_data ? ls_addr_i : pc;

    // R3
    not_taken_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && ex_valid_o && !br_taken_i && !hold_i && !mem_sel_data_o)
        |=> (mem_sel_data_o || mem_addr_o == $past(mem_addr_o) + INC));

    // R4
    taken_squash_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && ex_valid_o && br_taken_i && !hold_i)
        |=> (!dec_valid_o && ex_valid_o));

    // R6
    ls_enter_data_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_DATA && dec_valid_o && ls_req_i && !hold_i)
        |=> (mem_sel_data_o && ex_valid_o));

    // R7
    data_port_release_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_sel_data_o && !hold_i) |=> !mem_sel_data_o);

endmodule

// File: tb/fetch_seq_test.sv
module fetch_seq_test;

    localparam int AW = 32;
    localparam int NV = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_i = 1'b0;
    logic          ls_req_i = 1'b0;
    logic [AW-1:0] ls_addr_i = '0;
    logic          br_taken_i = 1'b0;
    logic [AW-1:0] br_target_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_sel_data_o;
    logic          dec_valid_o;
    logic          ex_valid_o;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fetch_seq #(.AW(AW), .STEP(4), .RESET_PC('0)) uut (
        .clk            (clk),
        .rst            (rst),
        .hold_i         (hold_i),
        .ls_req_i       (ls_req_i),
        .ls_addr_i      (ls_addr_i),
        .br_taken_i     (br_taken_i),
        .br_target_i    (br_target_i),
        .mem_addr_o     (mem_addr_o),
        .mem_sel_data_o (mem_sel_data_o),
        .dec_valid_o    (dec_valid_o),
        .ex_valid_o     (ex_valid_o)
    );

    // {req4, hold, ls, br, target16, lsaddr16, exp_addr16, exp_sel, exp_dv, exp_xv}
    localparam logic [57:0] VEC [0:NV-1] = '{
        {4'd1,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0,1'b0,1'b0}, // R1 reset state
        {4'd2,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0004, 1'b0,1'b1,1'b0}, // R2
        {4'd3,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0008, 1'b0,1'b1,1'b1}, // R3 not taken
        {4'd4,  1'b0,1'b0,1'b1, 16'h0100, 16'h0000, 16'h000C, 1'b0,1'b1,1'b1}, // R4 taken
        {4'd4,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0100, 1'b0,1'b0,1'b1}, // R4 squash
        {4'd5,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0104, 1'b0,1'b1,1'b0}, // R5 bubble
        {4'd5,  1'b0,1'b1,1'b0, 16'h0000, 16'h0000, 16'h0108, 1'b0,1'b1,1'b1}, // R5 target in ex
        {4'd6,  1'b0,1'b0,1'b1, 16'h0400, 16'h8000, 16'h8000, 1'b1,1'b1,1'b1}, // R6 data
        {4'd7,  1'b0,1'b0,1'b1, 16'h0400, 16'h0000, 16'h010C, 1'b0,1'b1,1'b1}, // R7 resume
        {4'd10, 1'b1,1'b1,1'b1, 16'h0500, 16'h0000, 16'h0110, 1'b0,1'b1,1'b1}, // R10 hold
        {4'd10, 1'b1,1'b1,1'b1, 16'h0500, 16'h0000, 16'h0110, 1'b0,1'b1,1'b1}, // R10 hold
        {4'd10, 1'b0,1'b1,1'b0, 16'h0000, 16'h0000, 16'h0110, 1'b0,1'b1,1'b1}, // R10 release
        {4'd6,  1'b0,1'b0,1'b0, 16'h0000, 16'h9000, 16'h9000, 1'b1,1'b1,1'b1}, // R6
        {4'd8,  1'b0,1'b1,1'b0, 16'h0000, 16'h0000, 16'h0114, 1'b0,1'b1,1'b1}, // R8
        {4'd8,  1'b0,1'b0,1'b0, 16'h0000, 16'hA000, 16'hA000, 1'b1,1'b1,1'b1}, // R8 again data
        {4'd7,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0118, 1'b0,1'b1,1'b1}, // R7
        {4'd9,  1'b0,1'b1,1'b1, 16'h0200, 16'h0000, 16'h011C, 1'b0,1'b1,1'b1}, // R9
        {4'd10, 1'b1,1'b0,1'b0, 16'h0000, 16'hB000, 16'hB000, 1'b1,1'b0,1'b1}, // R10 hold in data
        {4'd9,  1'b0,1'b0,1'b0, 16'h0000, 16'hB000, 16'hB000, 1'b1,1'b0,1'b1}, // R9 data
        {4'd9,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0200, 1'b0,1'b0,1'b1}, // R9 resume at target
        {4'd9,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0204, 1'b0,1'b1,1'b0}, // R9
        {4'd2,  1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 16'h0208, 1'b0,1'b1,1'b1}  // R2
    };

    task automatic compare(input int req, input logic [AW-1:0] ea,
                           input logic es, input logic edv, input logic exv);
        n_vec++;
        if (mem_addr_o !== ea || mem_sel_data_o !== es ||
            dec_valid_o !== edv || ex_valid_o !== exv) begin
            n_bad++;
            $display("FAIL R%0d: got addr=%h sel=%b dv=%b xv=%b, want addr=%h sel=%b dv=%b xv=%b",
                     req, mem_addr_o, mem_sel_data_o, dec_valid_o, ex_valid_o,
                     ea, es, edv, exv);
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hung run, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            if (i > 0) @(negedge clk);
            hold_i      = VEC[i][53];
            ls_req_i    = VEC[i][52];
            br_taken_i  = VEC[i][51];
            br_target_i = AW'(VEC[i][50:35]);
            ls_addr_i   = AW'(VEC[i][34:19]);
            #1;
            compare(int'(VEC[i][57:54]), AW'(VEC[i][18:3]),
                    VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        // directed: load/store then reset while in DATA (R6, R1)
        @(negedge clk);
        hold_i = 1'b0; br_taken_i = 1'b0; ls_req_i = 1'b1; ls_addr_i = 32'h0000_C000;
        #1;
        compare(2, 32'h0000_020C, 1'b0, 1'b1, 1'b1); // R2
        @(negedge clk);
        ls_req_i = 1'b0;
        #1;
        compare(6, 32'h0000_C000, 1'b1, 1'b1, 1'b1); // R6
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare(1, 32'h0000_0000, 1'b0, 1'b0, 1'b0); // R1 reset from DATA
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule